// File: doc/BRIEF.md
# Interrupt Flag and Enable Register Bank

This block keeps one pending flag and one enable bit for each interrupt source of a small microcontroller. It feeds a set of combined request lines to a downstream interrupt arbiter. Hardware event pulses set the flags. Software clears a peripheral flag by writing a byte in which that flag's bit is zero; bits written as one leave their flags alone. A mask of all ones except the target bit therefore clears exactly one flag. A flag whose event arrives while the write is in flight cannot be lost.

Seven primary request lines exist. Two of them are shared. Line 6 collects four system sub-sources: transfer-busy, RTC one-second tick, RTC one-minute tick and RTC alarm. Line 2 collects four compute-engine pulse sub-sources, named X, Y, W and V. The SPI and EEPROM sources each have their own flag, enable and request output. Each primary line also has a flag that the arbiter clears with a vector-acknowledge strobe once it vectors to that line's handler. Software reads and writes all state through a byte-addressed bus. Reads are combinational and follow the address directly.

Top module: `irq_flag_bank`

## Requirements
- R1: After reset every flag and every enable is 0. Every register reads 0, and all request outputs (`irq_line`, `irq_spi`, `irq_eep`) are 0.
- R2: An event pulse that is high at a rising clock edge sets its flag, whatever the state of its enable. The peripheral flag byte (address 2) has these bits: 0 transfer-busy, 1 RTC second, 2 RTC minute, 3 RTC alarm, 4 SPI, 5 EEPROM. The pulse flag byte (address 4) has these bits: 0 X, 1 Y, 2 W, 3 V.
- R3: A bus write to address 2 or address 4 clears each flag whose bit in the write data is 0. Flags whose bit is written as 1 keep their value.
- R4: When a set and a clear hit the same flag in the same cycle, the flag ends up set. The clear may come from a bus write or from an acknowledge.
- R5: The enable bytes are read/write. Address 1 holds the line enables in bits 6:0. Address 3 holds the peripheral enables, with the same bit layout as address 2. Address 5 holds the pulse enables, with the same bit layout as address 4. Bits with no enable behind them read as 0.
- R6: `irq_line[6]` is high exactly when line enable 6 is set and at least one of bits 3:0 at address 2 has both its flag and its enable set.
- R7: `irq_line[2]` is high exactly when line enable 2 is set and at least one of bits 3:0 at address 4 has both its flag and its enable set.
- R8: `irq_spi` equals the AND of flag bit 4 and enable bit 4. `irq_eep` equals the AND of flag bit 5 and enable bit 5.
- R9: The primary flags (address 0, bits 6:0) cannot be changed by bus writes. A pulse on `ack_vec[k]` clears primary flag k.
- R10: For lines 0, 1, 3, 4 and 5, `irq_line[k]` equals primary flag k AND line enable k. `ext_evt[k]` sets primary flag k on any line. Primary flag 6 is also set by any line-6 sub-event whose sub-enable is set, and primary flag 2 by any line-2 sub-event whose sub-enable is set.
- R11: Addresses 6 and 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_evt | input | 7 | Per-line event pulses that set the primary flags |
| sys_evt | input | 4 | Line-6 sub-source event pulses (transfer-busy, RTC second, RTC minute, RTC alarm) |
| ce_evt | input | 4 | Line-2 compute-engine pulse events (X, Y, W, V) |
| spi_evt | input | 1 | SPI event pulse |
| eep_evt | input | 1 | EEPROM event pulse |
| ack_vec | input | 7 | Vector-acknowledge strobes that clear the primary flags |
| bus_sel | input | 1 | Bus access select |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 3 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| irq_line | output | 7 | Combined request lines to the arbiter |
| irq_spi | output | 1 | SPI request |
| irq_eep | output | 1 | EEPROM request |

## Verification
A corrupted flag or enable bit shows up at the ports within the cycle that follows the edge that stored it. It appears at once on `bus_rdata` for its address, and on the request output it feeds if that path is enabled. The sweeps cover every combination of the six peripheral flags against their six enables, and every combination of the four pulse flags against their enables. Both shared lines are tried with the line enable on and off. A wrong term in any OR reduction or enable gate therefore produces a wrong request bit in the first cycle after the event pulse. The set-wins ordering, the ignored written ones and the read-only primary byte are each checked by reading the register back in the cycle right after the conflicting write.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_PFLAG = 3'd0,
        A_PEN   = 3'd1,
        A_SFLAG = 3'd2,
        A_SEN   = 3'd3,
        A_CFLAG = 3'd4,
        A_CEN   = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/irq_flag_vec.sv
module irq_flag_vec #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q_r;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q_r[gi] <= 1'b0;
                else if (set_i[gi])
                    q_r[gi] <= 1'b1;
                else if (clr_i[gi])
                    q_r[gi] <= 1'b0;
            end
        end
    endgenerate

    assign q_o = q_r;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((q_r & $past(set_i)) == $past(set_i))); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i == '0) && (clr_i == '0)) |=> $stable(q_r)); // R3
endmodule

// File: rtl/irq_share_or.sv
module irq_share_or #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] flag_i,
    input  logic [W-1:0] en_i,
    input  logic         line_en_i,
    output logic         req_o
);
    logic [W-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_term
            assign hit[gi] = flag_i[gi] & en_i[gi];
        end
    endgenerate

    assign req_o = line_en_i & (|hit);
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
    import irq_flag_pkg::*;
#(
    parameter int unsigned NUM_LINES = 7,
    parameter int unsigned GRP_W     = 4,
    parameter int unsigned LINE_SYS  = 6,
    parameter int unsigned LINE_CE   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] ext_evt,
    input  logic [GRP_W-1:0]     sys_evt,
    input  logic [GRP_W-1:0]     ce_evt,
    input  logic                 spi_evt,
    input  logic                 eep_evt,
    input  logic [NUM_LINES-1:0] ack_vec,
    input  logic                 bus_sel,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] irq_line,
    output logic                 irq_spi,
    output logic                 irq_eep
);
    localparam int unsigned SYS_W   = GRP_W + 2;
    localparam int unsigned BIT_SPI = GRP_W;
    localparam int unsigned BIT_EEP = GRP_W + 1;

    logic [NUM_LINES-1:0] pflag, pen, pset;
    logic [SYS_W-1:0]     sflag, sen, sset, sclr;
    logic [GRP_W-1:0]     cflag, cen, cclr;
    logic                 wr_pen, wr_sflag, wr_sen, wr_cflag, wr_cen;
    logic                 sys_req, ce_req;
    logic                 unused_wdata;

    assign unused_wdata = ^bus_wdata;

    // write decode
    always_comb begin
        wr_pen   = bus_sel && bus_we && (bus_addr == A_PEN);
        wr_sflag = bus_sel && bus_we && (bus_addr == A_SFLAG);
        wr_sen   = bus_sel && bus_we && (bus_addr == A_SEN);
        wr_cflag = bus_sel && bus_we && (bus_addr == A_CFLAG);
        wr_cen   = bus_sel && bus_we && (bus_addr == A_CEN);
    end

    // set and clear vectors
    always_comb begin
        sset = {eep_evt, spi_evt, sys_evt};
        sclr = wr_sflag ? ~bus_wdata[SYS_W-1:0] : '0;
        cclr = wr_cflag ? ~bus_wdata[GRP_W-1:0] : '0;
        pset = ext_evt;
        pset[LINE_SYS] = ext_evt[LINE_SYS] | (|(sys_evt & sen[GRP_W-1:0]));
        pset[LINE_CE]  = ext_evt[LINE_CE]  | (|(ce_evt & cen));
    end

    irq_flag_vec #(.W(NUM_LINES)) u_pflag (
        .clk(clk), .rst_n(rst_n), .set_i(pset), .clr_i(ack_vec), .q_o(pflag)
    );

    irq_flag_vec #(.W(SYS_W)) u_sflag (
        .clk(clk), .rst_n(rst_n), .set_i(sset), .clr_i(sclr), .q_o(sflag)
    );

    irq_flag_vec #(.W(GRP_W)) u_cflag (
        .clk(clk), .rst_n(rst_n), .set_i(ce_evt), .clr_i(cclr), .q_o(cflag)
    );

    // enable registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pen <= '0;
            sen <= '0;
            cen <= '0;
        end else begin
            if (wr_pen) pen <= bus_wdata[NUM_LINES-1:0];
            if (wr_sen) sen <= bus_wdata[SYS_W-1:0];
            if (wr_cen) cen <= bus_wdata[GRP_W-1:0];
        end
    end

    irq_share_or #(.W(GRP_W)) u_sys_or (
        .flag_i(sflag[GRP_W-1:0]), .en_i(sen[GRP_W-1:0]),
        .line_en_i(pen[LINE_SYS]), .req_o(sys_req)
    );

    irq_share_or #(.W(GRP_W)) u_ce_or (
        .flag_i(cflag), .en_i(cen), .line_en_i(pen[LINE_CE]), .req_o(ce_req)
    );

    genvar gl;
    generate
        for (gl = 0; gl < NUM_LINES; gl++) begin : g_line
            if (gl == LINE_SYS) begin : g_sys
                assign irq_line[gl] = sys_req;
            end else if (gl == LINE_CE) begin : g_ce
                assign irq_line[gl] = ce_req;
            end else begin : g_own
                assign irq_line[gl] = pflag[gl] & pen[gl];
            end
        end
    endgenerate

    assign irq_spi = sflag[BIT_SPI] & sen[BIT_SPI];
    assign irq_eep = sflag[BIT_EEP] & sen[BIT_EEP];

    // read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_PFLAG: bus_rdata[NUM_LINES-1:0] = pflag;
            A_PEN:   bus_rdata[NUM_LINES-1:0] = pen;
            A_SFLAG: bus_rdata[SYS_W-1:0]     = sflag;
            A_SEN:   bus_rdata[SYS_W-1:0]     = sen;
            A_CFLAG: bus_rdata[GRP_W-1:0]     = cflag;
            A_CEN:   bus_rdata[GRP_W-1:0]     = cen;
            default: bus_rdata = '0;
        endcase
    end

    AST_PFLAG_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_we && pset == '0 && ack_vec == '0) |=> $stable(pflag)); // R9

    AST_ACK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack_vec & ~pset)) |=> ((pflag & $past(ack_vec & ~pset)) == '0)); // R9

    AST_ONES_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sflag && (&bus_wdata[SYS_W-1:0]) && sset == '0) |=> $stable(sflag)); // R3

    AST_LINE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_line & ~pen) == '0)); // R10
endmodule

// File: tb/test_irq_flag_bank.sv
module test_irq_flag_bank;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] ext_evt, ack_vec, irq_line;
    logic [3:0] sys_evt, ce_evt;
    logic       spi_evt, eep_evt, bus_sel, bus_we, irq_spi, irq_eep;
    logic [2:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;

    int errors = 0;
    int checks = 0;
    int cyc_cnt = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    irq_flag_bank i_irq_flag_bank (
        .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt), .sys_evt(sys_evt),
        .ce_evt(ce_evt), .spi_evt(spi_evt), .eep_evt(eep_evt), .ack_vec(ack_vec),
        .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_line(irq_line),
        .irq_spi(irq_spi), .irq_eep(irq_eep)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_in();
        ext_evt = '0; ack_vec = '0; sys_evt = '0; ce_evt = '0;
        spi_evt = 1'b0; eep_evt = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic cyc();
        @(negedge clk);
        idle_in();
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        cyc();
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt >= 150000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=done", cyc_cnt);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        idle_in();
        bus_addr = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R1 reset register", d, 0);
        end
        chk("R1 reset requests", {irq_line, irq_spi, irq_eep}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 enable readback and unused bits
        wr(3'd1, 8'hFF); rd(3'd1, d); chk("R5 line enables", d, 8'h7F);
        wr(3'd3, 8'hFF); rd(3'd3, d); chk("R5 peripheral enables", d, 8'h3F);
        wr(3'd5, 8'hFF); rd(3'd5, d); chk("R5 pulse enables", d, 8'h0F);
        wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd5, 8'h00);
        rd(3'd3, d); chk("R5 enable cleared", d, 0);

        // R11 unmapped addresses
        wr(3'd6, 8'hFF); wr(3'd7, 8'hFF);
        rd(3'd6, d); chk("R11 addr6", d, 0);
        rd(3'd7, d); chk("R11 addr7", d, 0);
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            chk("R11 no side effect", d, 0);
        end

        // R2 / R3 single-bit behaviour
        spi_evt = 1'b1; cyc();
        rd(3'd2, d); chk("R2 spi flag", d, 8'h10);
        wr(3'd2, 8'hFF); rd(3'd2, d); chk("R3 ones ignored", d, 8'h10);
        sys_evt = 4'hF; eep_evt = 1'b1; cyc();
        rd(3'd2, d); chk("R2 all peripheral flags", d, 8'h3F);
        wr(3'd2, 8'hFB); rd(3'd2, d); chk("R3 mask clears one bit", d, 8'h3B);
        wr(3'd2, 8'h00); rd(3'd2, d); chk("R3 clear all", d, 0);

        // R4 set wins over bus clear
        sys_evt = 4'h2; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd2; bus_wdata = 8'h00;
        cyc();
        rd(3'd2, d); chk("R4 set beats write clear", d, 8'h02);
        wr(3'd2, 8'h00);

        // R3 mask sweep on pulse byte
        ce_evt = 4'hF; cyc();
        for (int b = 0; b < 4; b++) begin
            wr(3'd4, ~(8'h01 << b));
            rd(3'd4, d);
            chk("R3 pulse mask", d, 8'h0F & ~((8'h02 << b) - 8'h01));
        end

        // R9 primary flags
        ext_evt = 7'h7F; cyc();
        rd(3'd0, d); chk("R10 ext sets primary", d, 8'h7F);
        wr(3'd0, 8'h00); rd(3'd0, d); chk("R9 primary read-only", d, 8'h7F);
        ack_vec = 7'h01; cyc(); rd(3'd0, d); chk("R9 ack clears", d, 8'h7E);
        ack_vec = 7'h08; ext_evt = 7'h08; cyc();
        rd(3'd0, d); chk("R4 set beats ack", d, 8'h7E);
        ack_vec = 7'h7F; cyc(); rd(3'd0, d); chk("R9 ack all", d, 0);

        // R10 unshared lines
        for (int k = 0; k < 7; k++) begin
            if (k == 2 || k == 6) continue;
            ext_evt = 7'(1 << k); cyc();
            chk("R10 line off when disabled", irq_line, 0);
            wr(3'd1, 8'(1 << k));
            chk("R10 line on", irq_line, 32'(1 << k));
            ack_vec = 7'(1 << k); cyc();
            chk("R10 line drops after ack", irq_line, 0);
            wr(3'd1, 8'h00);
        end

        // R6 / R8 sweep over peripheral flags and enables
        for (int f = 0; f < 64; f++) begin
            for (int e = 0; e < 64; e++) begin
                logic l6, any;
                l6 = logic'(((f >> 1) ^ e) & 1);
                any = |(f[3:0] & e[3:0]);
                ack_vec = 7'h7F; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd1;
                bus_wdata = {1'b0, l6, 6'b0};
                cyc();
                wr(3'd3, 8'(e));
                wr(3'd2, 8'h00);
                sys_evt = f[3:0]; spi_evt = f[4]; eep_evt = f[5];
                cyc();
                rd(3'd2, d); chk("R2 peripheral flags", d, 32'(f));
                rd(3'd0, d); chk("R10 shared primary 6", d, 32'({1'b0, any, 6'b0}));
                chk("R6 line 6 request", irq_line, 32'({l6 & any, 6'b0}));
                chk("R8 spi request", irq_spi, 32'(f[4] & e[4]));
                chk("R8 eeprom request", irq_eep, 32'(f[5] & e[5]));
            end
        end

        // R7 sweep over pulse flags and enables
        for (int f = 0; f < 16; f++) begin
            for (int e = 0; e < 16; e++) begin
                for (int l = 0; l < 2; l++) begin
                    logic any;
                    any = |(f[3:0] & e[3:0]);
                    ack_vec = 7'h7F; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 3'd1;
                    bus_wdata = 8'(l << 2);
                    cyc();
                    wr(3'd5, 8'(e));
                    wr(3'd4, 8'h00);
                    ce_evt = f[3:0];
                    cyc();
                    rd(3'd4, d); chk("R2 pulse flags", d, 32'(f));
                    rd(3'd0, d); chk("R10 shared primary 2", d, 32'(any) << 2);
                    chk("R7 line 2 request", irq_line, 32'(l[0] & any) << 2);
                end
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule